// File: doc/BRIEF.md
# Sixteen-Pin GPIO Port with Edge Interrupts

This block is a memory-mapped general-purpose I/O port for sixteen pins. Software reaches it through a single-cycle register port: a byte address, an access-size code, a write strobe, write data, and read data that is valid in the same cycle. Each pin is an input or an output, chosen one bit per pin. Output pins drive the value held in an output latch. Input pins pass through a two-stage synchronizer, so their levels can be read back and watched for edges.

Each input pin has a polarity bit that picks which edge it watches: rising or falling. An edge on an input pin that is not masked sets a sticky status bit. While any status bit is set, the single interrupt request is high. Software clears status bits by writing ones to them.

A pin-control register gates the value returned by an input-data read. Most registers come out of reset as all ones, so after reset every pin is an input and every interrupt is masked.

Top module: `gpio16_port`

## Requirements
- R1: After reset the output latch, direction, polarity, mask and pin-control registers read 0xFFFF; the status register and the input-data read return 0x0000; irq, pin_oe and pin_out are all zero.
- R2: With bus_size = 2'b01 (16-bit), the registers sit at these byte offsets: output latch 0x04, direction 0x08, polarity 0x0C, mask 0x10, status 0x14, pin control 0x18. Each of the five writable registers reads back the last value written to it.
- R3: Direction bit 1 = input, 0 = output. pin_oe[i] is the inverse of the direction bit. pin_out[i] equals the latch bit when the pin is an output and 0 when it is an input. Both follow a write to the latch or direction register in the cycle after that write.
- R4: A read of offset 0x00 returns the synchronized pin levels ANDed bitwise with the pin-control register. A pin change becomes visible in this read after at most three clock edges.
- R5: On an input pin, polarity bit 1 makes a 0-to-1 transition set that pin's status bit, and polarity bit 0 makes a 1-to-0 transition set it. A transition in the other direction sets nothing.
- R6: A pin whose direction bit is 0, or whose mask bit is 1, never sets its status bit.
- R7: A status bit, once set, stays set after the pin returns to its earlier level. irq stays high while any status bit is 1.
- R8: Writing to the status register clears exactly those bits written as 1. irq falls only once every status bit is zero.
- R9: A write with bus_size other than 2'b01 changes no register. A read with bus_size other than 2'b01 returns zero. Size codes: 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit.
- R10: Reads of unmapped offsets (anything other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18) return zero. Writes to unmapped offsets, or to offset 0x00, change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_size | input | 2 | Access size code (2'b01 = 16-bit) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and size |
| pin_in | input | 16 | Asynchronous pad input levels |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 = drive |
| irq | output | 1 | Interrupt request, high while any status bit is set |

## Verification
Edge detection is swept over every pin, with both polarity values and both transition directions, and only that pin unmasked. This shows that the right bit latches, that the opposite edge is ignored, and that no neighbouring bit is touched. The same pin-by-pin sweep over the direction register separates output-enable inversion from latch gating. Masked pins and output pins are toggled to show that they cannot raise status. Two-bit set-then-partial-clear sequences separate sticky status from level-following status, and they show irq falling only on the last clear. Writes with the wrong size, to unmapped offsets and to the read-only input offset are each followed by a full readback, so that a silently corrupted register is seen.

// File: rtl/gp_pkg.sv
`timescale 1ns/1ps
package gp_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  localparam int OFS_LEVEL = 'h00;
  localparam int OFS_LATCH = 'h04;
  localparam int OFS_DIR   = 'h08;
  localparam int OFS_POL   = 'h0C;
  localparam int OFS_MASK  = 'h10;
  localparam int OFS_STAT  = 'h14;
  localparam int OFS_GATE  = 'h18;

  typedef struct packed {
    logic latch;
    logic dir;
    logic pol;
    logic mask;
    logic stat;
    logic gate;
  } wr_stb_t;

  typedef struct packed {
    logic level;
    logic latch;
    logic dir;
    logic pol;
    logic mask;
    logic stat;
    logic gate;
  } rd_sel_t;

endpackage

// File: rtl/gp_decode.sv
`timescale 1ns/1ps
module gp_decode
  import gp_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic          we,
  output wr_stb_t       wstb,
  output rd_sel_t       rsel
);

  logic    size_ok;
  rd_sel_t hit;

  assign size_ok = (size == SZ_HALF);

  // One-hot address match; unmapped offsets leave every field clear.
  always_comb begin
    hit       = '0;
    hit.level = (addr == AW'(OFS_LEVEL));
    hit.latch = (addr == AW'(OFS_LATCH));
    hit.dir   = (addr == AW'(OFS_DIR));
    hit.pol   = (addr == AW'(OFS_POL));
    hit.mask  = (addr == AW'(OFS_MASK));
    hit.stat  = (addr == AW'(OFS_STAT));
    hit.gate  = (addr == AW'(OFS_GATE));
  end

  always_comb begin
    rsel = size_ok ? hit : '0;
    wstb = '0;
    if (we && size_ok) begin
      wstb.latch = hit.latch;
      wstb.dir   = hit.dir;
      wstb.pol   = hit.pol;
      wstb.mask  = hit.mask;
      wstb.stat  = hit.stat;
      wstb.gate  = hit.gate;
    end
  end

endmodule

// File: rtl/gp_sync_edge.sv
`timescale 1ns/1ps
module gp_sync_edge #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  localparam int LAST = STAGES - 1;

  logic [W-1:0] stg [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= pin_in;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stg[LAST];
  end

  assign level = stg[LAST];
  assign rise  = stg[LAST] & ~prev_q;
  assign fall  = ~stg[LAST] & prev_q;

  // R4
  sync_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prev_q == $past(stg[LAST]));

endmodule

// File: rtl/gp_regfile.sv
`timescale 1ns/1ps
module gp_regfile
  import gp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_stb_t      wstb,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] rise,
  input  logic [W-1:0] fall,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] stat_q,
  output logic [W-1:0] gate_q,
  output logic         irq
);

  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic [W-1:0] edge_hit;
  logic [W-1:0] clr_bits;
  logic [W-1:0] stat_d;
  logic         stat_en;

  // Next-state logic
  always_comb begin
    edge_hit = ((pol_q & rise) | (~pol_q & fall)) & dir_q & ~mask_q;
    clr_bits = wstb.stat ? wdata : '0;
    stat_d   = (stat_q & ~clr_bits) | edge_hit;
    stat_en  = wstb.stat | (|edge_hit);
  end

  // Registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= ONES;
    else if (wstb.latch) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= ONES;
    else if (wstb.dir) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pol_q <= ONES;
    else if (wstb.pol) pol_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= ONES;
    else if (wstb.mask) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= ONES;
    else if (wstb.gate) gate_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign irq = |stat_q;

  // R6
  no_blocked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q)) & ($past(mask_q) | ~$past(dir_q))) == '0);

  // R7
  stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wstb.stat) |-> ((stat_q & $past(stat_q)) == $past(stat_q)));

  // R8
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wstb.stat));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wstb == '0) |=> ($stable(latch_q) && $stable(dir_q) && $stable(pol_q)
                      && $stable(mask_q) && $stable(gate_q)));

endmodule

// File: rtl/gpio16_port.sv
`timescale 1ns/1ps
module gpio16_port
  import gp_pkg::*;
#(
  parameter int W  = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [1:0]    bus_size,
  input  logic          bus_we,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic          irq
);

  wr_stb_t      wstb;
  rd_sel_t      rsel;
  logic [W-1:0] level, rise, fall;
  logic [W-1:0] latch_q, dir_q, pol_q, mask_q, stat_q, gate_q;

  gp_decode #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .size (bus_size),
    .we   (bus_we),
    .wstb (wstb),
    .rsel (rsel)
  );

  gp_sync_edge #(.W(W), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .level  (level),
    .rise   (rise),
    .fall   (fall)
  );

  gp_regfile #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wstb    (wstb),
    .wdata   (bus_wdata),
    .rise    (rise),
    .fall    (fall),
    .latch_q (latch_q),
    .dir_q   (dir_q),
    .pol_q   (pol_q),
    .mask_q  (mask_q),
    .stat_q  (stat_q),
    .gate_q  (gate_q),
    .irq     (irq)
  );

  // Read mux: all selects are zero for a bad size or unmapped offset.
  always_comb begin
    bus_rdata = '0;
    if (rsel.level) bus_rdata = level & gate_q;
    if (rsel.latch) bus_rdata = latch_q;
    if (rsel.dir)   bus_rdata = dir_q;
    if (rsel.pol)   bus_rdata = pol_q;
    if (rsel.mask)  bus_rdata = mask_q;
    if (rsel.stat)  bus_rdata = stat_q;
    if (rsel.gate)  bus_rdata = gate_q;
  end

  assign pin_oe  = ~dir_q;
  assign pin_out = latch_q & ~dir_q;

  // R3
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

endmodule

// File: tb/gpio16_port_tb.sv
`timescale 1ns/1ps
module gpio16_port_tb;

  localparam logic [1:0] SZ8  = 2'b00;
  localparam logic [1:0] SZ16 = 2'b01;
  localparam logic [1:0] SZ32 = 2'b10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [1:0]  bus_size;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] pin_in;
  logic [15:0] pin_out;
  logic [15:0] pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio16_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_size = SZ16;
  endtask

  task automatic rd(input string tag, input logic [7:0] a, input logic [1:0] sz,
                    input logic [15:0] exp);
    bus_addr = a; bus_size = sz; bus_we = 1'b0;
    #1;
    chk(tag, bus_rdata, exp);
    bus_size = SZ16;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_check(input string tag, input logic [15:0] l, input logic [15:0] d,
                           input logic [15:0] p, input logic [15:0] m, input logic [15:0] g);
    rd(tag, 8'h04, SZ16, l);
    rd(tag, 8'h08, SZ16, d);
    rd(tag, 8'h0C, SZ16, p);
    rd(tag, 8'h10, SZ16, m);
    rd(tag, 8'h18, SZ16, g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_size = SZ16; bus_we = 1'b0;
    bus_wdata = '0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    cfg_check("R1 reset regs", 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    rd("R1 reset status", 8'h14, SZ16, 16'h0000);
    rd("R1 reset level", 8'h00, SZ16, 16'h0000);
    chk("R1 reset irq", {15'd0, irq}, 16'h0000);
    chk("R1 reset oe", pin_oe, 16'h0000);
    chk("R1 reset out", pin_out, 16'h0000);

    // R2 readback of all writable registers
    wr(8'h04, 16'h1234, SZ16); wr(8'h08, 16'hFFFF, SZ16);
    wr(8'h0C, 16'h0F0F, SZ16); wr(8'h10, 16'hAAAA, SZ16);
    wr(8'h18, 16'h5555, SZ16);
    cfg_check("R2 readback", 16'h1234, 16'hFFFF, 16'h0F0F, 16'hAAAA, 16'h5555);

    // R3 per-pin drive sweep
    for (int i = 0; i < 16; i++) begin
      logic [15:0] lat;
      logic [15:0] dv;
      lat = 16'hC35A ^ (16'h0101 << (i % 8));
      dv  = ~(16'h1 << i);
      wr(8'h04, lat, SZ16);
      wr(8'h08, dv, SZ16);
      chk($sformatf("R3 oe pin%0d", i), pin_oe, ~dv);
      chk($sformatf("R3 out pin%0d", i), pin_out, lat & ~dv);
    end
    wr(8'h08, 16'h00FF, SZ16);
    wr(8'h04, 16'hA5C3, SZ16);
    chk("R3 latch write drives next cycle", pin_out, 16'hA5C3 & 16'hFF00);
    wr(8'h08, 16'hFFFF, SZ16);
    chk("R3 all inputs", pin_out | pin_oe, 16'h0000);

    // R4 level read gated by pin control
    pin_in = 16'h5A5A; settle();
    wr(8'h18, 16'h0FF0, SZ16);
    rd("R4 gated level", 8'h00, SZ16, 16'h0A50);
    wr(8'h18, 16'hFFFF, SZ16);
    rd("R4 open level", 8'h00, SZ16, 16'h5A5A);
    pin_in = 16'h0000; settle();
    rd("R4 level low", 8'h00, SZ16, 16'h0000);

    // R5 edge sweep over pins and polarities
    wr(8'h14, 16'hFFFF, SZ16);
    for (int i = 0; i < 16; i++) begin
      for (int p = 0; p < 2; p++) begin
        logic [15:0] b;
        b = 16'h1 << i;
        wr(8'h0C, (p == 1) ? b : 16'h0000, SZ16);
        wr(8'h10, ~b, SZ16);
        pin_in = b; settle();
        rd($sformatf("R5 up pin%0d pol%0d", i, p), 8'h14, SZ16, (p == 1) ? b : 16'h0);
        pin_in = 16'h0; settle();
        rd($sformatf("R5 down pin%0d pol%0d", i, p), 8'h14, SZ16, b);
        chk($sformatf("R7 irq pin%0d", i), {15'd0, irq}, 16'h0001);
        wr(8'h14, b, SZ16);
        rd($sformatf("R8 clear pin%0d", i), 8'h14, SZ16, 16'h0000);
        chk($sformatf("R8 irq low pin%0d", i), {15'd0, irq}, 16'h0000);
      end
    end

    // R6 masked pins and output pins never set status
    wr(8'h0C, 16'hFFFF, SZ16);
    wr(8'h10, 16'hFFFF, SZ16);
    pin_in = 16'hFFFF; settle(); pin_in = 16'h0; settle();
    rd("R6 masked", 8'h14, SZ16, 16'h0000);
    wr(8'h10, 16'h0000, SZ16);
    wr(8'h08, 16'h0000, SZ16);
    pin_in = 16'hFFFF; settle(); pin_in = 16'h0; settle();
    rd("R6 outputs", 8'h14, SZ16, 16'h0000);
    chk("R6 irq", {15'd0, irq}, 16'h0000);
    wr(8'h08, 16'hFFFF, SZ16);

    // R7 sticky and R8 partial clear
    pin_in = 16'h0081; settle();
    pin_in = 16'h0000; settle();
    rd("R7 sticky", 8'h14, SZ16, 16'h0081);
    wr(8'h14, 16'h0001, SZ16);
    rd("R8 partial", 8'h14, SZ16, 16'h0080);
    chk("R8 irq held", {15'd0, irq}, 16'h0001);
    wr(8'h14, 16'h0080, SZ16);
    chk("R8 irq drop", {15'd0, irq}, 16'h0000);

    // R9 bad-size accesses
    wr(8'h10, 16'hFFFF, SZ16);
    wr(8'h04, 16'h1111, SZ16); wr(8'h18, 16'hFFFF, SZ16);
    wr(8'h04, 16'h2222, SZ32);
    wr(8'h08, 16'h0000, SZ8);
    wr(8'h10, 16'h0000, 2'b11);
    cfg_check("R9 bad write", 16'h1111, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    rd("R9 read size8", 8'h04, SZ8, 16'h0000);
    rd("R9 read size32", 8'h08, SZ32, 16'h0000);

    // R10 unmapped and read-only offsets
    wr(8'h1C, 16'h0000, SZ16);
    wr(8'h00, 16'h0000, SZ16);
    wr(8'h06, 16'h0000, SZ16);
    cfg_check("R10 no effect", 16'h1111, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    rd("R10 read 0x1C", 8'h1C, SZ16, 16'h0000);
    rd("R10 read 0x02", 8'h02, SZ16, 16'h0000);
    rd("R10 read 0xFC", 8'hFC, SZ16, 16'h0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule